// File: doc/BRIEF.md
# Four-channel gated fractional clock-enable generator

This block takes one fast source clock and makes four enable pulse streams from it. Each stream runs at a rate of 18/F times the source rate, where F is a per-channel 6-bit fraction. The block divides by the non-integer ratio F/18 with an accumulator rather than a counter. The pulses are single-cycle enables in the source clock domain. Logic downstream uses them as clock enables, or as ticks whose average rate sets a reference frequency.

All control lives in one 32-bit register. Channel n owns byte n of it. Bits [8n+5:8n] hold the fraction and bit 8n+7 is the channel's gate: 1 stops the channel and 0 runs it. Software has three write flavours on the same port. A replace write loads the whole word. A set write ORs the data into it. A clear write removes the bits that are 1 in the data. With the set and clear writes, one channel's gate or fraction can change without a read-modify-write that would race other channels. The register is always visible on a read-back port.

Top module: `refclk_frac_bank`

## Requirements
- R1: After reset the register reads 32'h92929292: every gate bit is 1, every fraction is 18, and bit 6 of each byte is 0. All pulse outputs are low.
- R2: When `wr_en` is 1 and `wr_op` is 2'b00, the register takes all 32 bits of `wr_data`, and `rd_data` shows the new value after that clock edge.
- R3: When `wr_en` is 1 and `wr_op` is 2'b01, the register becomes its old value OR `wr_data`.
- R4: When `wr_en` is 1 and `wr_op` is 2'b10, the register becomes its old value AND NOT `wr_data`.
- R5: The register does not change when `wr_en` is 0, or when `wr_op` is 2'b11.
- R6: While bit 8n+7 is 1, `pulse_out[n]` stays low and the channel's accumulator is held at zero. After the gate is cleared, the pulse pattern starts again from the same phase as after reset.
- R7: On each clock edge, an ungated channel adds 18 to its accumulator. If the sum is at least the effective fraction F, the channel stores the sum minus F and drives `pulse_out[n]` high for the next cycle. Otherwise it stores the sum and drives the pulse low. For example, F=27 gives the repeating pattern low, high, high, and F=36 alternates low and high.
- R8: A fraction field value below 18, including 0, acts as 18, so the ungated channel pulses on every cycle and never stalls.
- R9: A fraction change written at one edge is used from the next edge on. The channel's accumulator keeps its value across the change, and the other channels' accumulators and pulse patterns are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_op | input | 2 | Write flavour: 00 replace, 01 set bits, 10 clear bits, 11 no effect |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control register value |
| pulse_out | output | 4 | One enable pulse stream per channel |

## Verification
A write applied before an edge shows on `rd_data` right after that same edge. The pulse that an edge computes, from the register and accumulator values it saw, is visible for the whole following cycle. The driver applies inputs on the falling edge and computes the expected register word and pulse vector for the next rising edge. It then queues this pair. The monitor pops one entry one nanosecond after each rising edge and compares it, so every result is checked in the cycle it is due and never at the edge itself.

// File: rtl/refclk_frac_bank.sv
module refclk_frac_bank #(
  parameter int NCH  = 4,
  parameter int LANE = 8,
  parameter int FW   = 6,
  parameter int NUM  = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_op,
  input  logic [NCH*LANE-1:0]  wr_data,
  output logic [NCH*LANE-1:0]  rd_data,
  output logic [NCH-1:0]       pulse_out
);
  localparam int RW = NCH * LANE;
  localparam int AW = $clog2((1 << FW) + NUM + 1);
  localparam int GB = LANE - 1;
  localparam logic [LANE-1:0] LANE_RST = LANE'((1 << GB) | NUM);
  localparam logic [AW-1:0] STEP = AW'(NUM);

  logic [RW-1:0] ctrl_q;
  logic [RW-1:0] ctrl_d;
  logic [AW-1:0] acc_q [NCH];
  logic          pulse_q [NCH];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_op)
        2'b00:   ctrl_d = wr_data;
        2'b01:   ctrl_d = ctrl_q | wr_data;
        2'b10:   ctrl_d = ctrl_q & ~wr_data;
        default: ctrl_d = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= {NCH{LANE_RST}};
    else        ctrl_q <= ctrl_d;
  end

  assign rd_data = ctrl_q;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic          gate;
    logic [FW-1:0] frac;
    logic [AW-1:0] f_eff;
    logic [AW-1:0] sum;
    logic          hit;

    assign gate  = ctrl_q[n*LANE + GB];
    assign frac  = ctrl_q[n*LANE +: FW];
    assign f_eff = (AW'(frac) < STEP) ? STEP : AW'(frac);
    assign sum   = acc_q[n] + STEP;
    assign hit   = sum >= f_eff;

    always_ff @(posedge clk) begin
      if (!rst_n || gate) begin
        acc_q[n]   <= '0;
        pulse_q[n] <= 1'b0;
      end else begin
        acc_q[n]   <= hit ? sum - f_eff : sum;
        pulse_q[n] <= hit;
      end
    end

    assign pulse_out[n] = pulse_q[n];
  end
endmodule

// File: rtl/refclk_frac_bank_sva.sv
module refclk_frac_bank_sva #(
  parameter int NCH  = 4,
  parameter int LANE = 8,
  parameter int FW   = 6,
  parameter int NUM  = 18,
  parameter int AW   = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [1:0]          wr_op,
  input logic [NCH*LANE-1:0] wr_data,
  input logic [NCH*LANE-1:0] rd_data,
  input logic [NCH-1:0]      pulse_out,
  input logic [AW-1:0]       acc [NCH]
);
  a_r2_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'b00) |=> rd_data == $past(wr_data));

  a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'b01) |=> rd_data == ($past(rd_data) | $past(wr_data)));

  a_r4_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'b10) |=> rd_data == ($past(rd_data) & ~$past(wr_data)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_op == 2'b11) |=> $stable(rd_data));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    a_r6_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[n*LANE + LANE - 1] |=> (!pulse_out[n] && acc[n] == '0));

    a_r8_small_frac: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[n*LANE + LANE - 1] && rd_data[n*LANE +: FW] <= FW'(NUM)) |=> pulse_out[n]);
  end
endmodule

bind refclk_frac_bank refclk_frac_bank_sva #(
  .NCH(NCH), .LANE(LANE), .FW(FW), .NUM(NUM), .AW(AW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
  .rd_data(rd_data), .pulse_out(pulse_out), .acc(acc_q)
);

// File: tb/refclk_frac_bank_tb.sv
`timescale 1ns/1ps
module refclk_frac_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = 2'b00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pulse_out;

  int checks = 0;
  int errors = 0;

  logic [35:0] q_exp [$];
  string       q_tag [$];

  logic [31:0] m_reg;
  int          m_acc [4];

  always #2 clk = ~clk;

  refclk_frac_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op),
    .wr_data(wr_data), .rd_data(rd_data), .pulse_out(pulse_out)
  );

  task automatic cyc(input bit en, input logic [1:0] op, input logic [31:0] d, input string tag);
    logic [3:0] p;
    @(negedge clk);
    wr_en = en; wr_op = op; wr_data = d;
    for (int n = 0; n < 4; n++) begin
      int f;
      int s;
      f = int'(m_reg[n*8 +: 6]);
      if (f < 18) f = 18;
      if (m_reg[n*8 + 7]) begin
        m_acc[n] = 0; p[n] = 1'b0;
      end else begin
        s = m_acc[n] + 18;
        p[n] = (s >= f);
        m_acc[n] = p[n] ? s - f : s;
      end
    end
    if (en) begin
      case (op)
        2'b00: m_reg = d;
        2'b01: m_reg = m_reg | d;
        2'b10: m_reg = m_reg & ~d;
        default: ;
      endcase
    end
    q_exp.push_back({p, m_reg});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int k, input string tag);
    for (int i = 0; i < k; i++) cyc(1'b0, 2'b00, 32'h0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        logic [35:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if ({pulse_out, rd_data} !== e) begin
          errors++;
          $display("FAIL %s: pulse=%b reg=%h expected pulse=%b reg=%h",
                   t, pulse_out, rd_data, e[35:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reg = 32'h92929292;
    for (int n = 0; n < 4; n++) m_acc[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    checks++;
    if (rd_data !== 32'h92929292 || pulse_out !== 4'b0) begin
      errors++;
      $display("FAIL R1: reg=%h pulse=%b expected reg=92929292 pulse=0000", rd_data, pulse_out);
    end
    idle(3, "R1");
    // ch0 gated f18, ch1 f0 (acts 18), ch2 f36, ch3 f27
    cyc(1'b1, 2'b00, 32'h1B240092, "R2");
    idle(6, "R7");
    idle(4, "R8");
    cyc(1'b1, 2'b01, 32'h80000000, "R3");
    idle(4, "R6");
    cyc(1'b1, 2'b10, 32'h80000000, "R4");
    idle(7, "R6");
    cyc(1'b1, 2'b11, 32'hFFFFFFFF, "R5");
    cyc(1'b0, 2'b00, 32'h00000000, "R5");
    cyc(1'b0, 2'b10, 32'hFFFFFFFF, "R5");
    idle(1, "R7");
    cyc(1'b1, 2'b10, 32'h003F0000, "R9");
    idle(2, "R9");
    cyc(1'b1, 2'b01, 32'h00140000, "R9");
    idle(8, "R9");
    cyc(1'b1, 2'b00, 32'h23221F14, "R2");
    idle(40, "R7");
    for (int i = 0; i < 300; i++)
      cyc(1'b1, 2'($urandom_range(0, 3)), $urandom, "R7");
    idle(3, "R7");
    wait (q_exp.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule